// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block is the digital sequencer for a 12-bit successive-approximation converter. It picks one start signal from a software start bit, an external start pin or one of several timer outputs. It passes that signal through a two-flop synchroniser and detects its edges. It then steps the converter through the power-up, track (acquisition), hold and conversion phases, counting clock cycles of the converter clock `clk`. The bit-trial logic is a stub: for a fixed twelve cycles it shifts the comparator input into a result register, most significant bit first.

The start signal can be read in one of two ways. In single-edge mode a rising edge starts the whole sequence from power-down. When the converter is already on, a falling edge starts acquisition and then conversion. In dual-edge mode the rising edge powers up the converter and opens acquisition, and the falling edge closes it and starts conversion. Acquisition is never shorter than the minimum. With auto-shutdown off, the block goes back to tracking once a conversion ends and power stays on. With auto-shutdown on, power drops after each conversion. The block also turns the channel configuration into positive and negative input selects for single-ended or differential operation.

Top module: `adc_trig_seq`

## Requirements
- R1: `src_sel` picks the start source: 0 is `sw_start`, 1 is `ext_start`, 2+i is `tmr_start[i]` for i below 4, and 6 or 7 selects a constant low. Unselected inputs have no effect.
- R2: Single-edge mode with power off: a rising source edge that is first present before edge E0 acts at edge E2, after two synchroniser flops. Power-up then lasts PWR_CYC=4 cycles and acquisition ACQ_CYC=3 cycles. `done` is seen after edge E2+PWR_CYC+ACQ_CYC+12.
- R3: Single-edge mode with power on: a rising edge is ignored. A falling edge acting at E2 starts acquisition, and `done` is seen after edge E2+ACQ_CYC+12.
- R4: Dual-edge mode: the rising edge (at E2) starts power-up if power is off, then acquisition. Conversion starts at the later of two edges: the falling-edge action edge, or the end of ACQ_CYC acquisition cycles. `done` follows 12 cycles after that.
- R5: With `auto_off`=0, in the cycle where `done` is high, `pwr_en` and `track` are both 1, so tracking resumes on the 13th cycle after conversion starts.
- R6: With `auto_off`=1, `pwr_en` is 0 from the `done` cycle on, and the next trigger repeats power-up. `track` is never 1 while `pwr_en` is 0.
- R7: Source edges that are acted on during a conversion are ignored: no extra `done` and no change in timing.
- R8: `result` holds the 12 comparator samples taken at the 12 conversion clock edges, the first sample in bit 11. `done` is high for exactly one cycle, the cycle in which `result` updates.
- R9: Single-ended (`diff_mode`=0): `pos_sel` = `mux_code` for codes 0..4 and 0 otherwise. `neg_sel` = 7, which means analog ground.
- R10: Differential (`diff_mode`=1): code 2 gives `pos_sel`=2 and `neg_sel`=3. Every other code gives `pos_sel`=0 and `neg_sel`=1.
- R11: After reset `pwr_en`, `track` and `done` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 3 | Start-source select |
| sw_start | input | 1 | Software start bit |
| ext_start | input | 1 | External start pin |
| tmr_start | input | 4 | Timer start outputs |
| dual_edge | input | 1 | 1: dual-edge mode, 0: single-edge |
| auto_off | input | 1 | Power down after each conversion |
| diff_mode | input | 1 | 1: differential, 0: single-ended |
| mux_code | input | 3 | Channel configuration code |
| cmp_in | input | 1 | Stub comparator decision |
| pwr_en | output | 1 | Converter power enable |
| track | output | 1 | 1: track, 0: hold |
| pos_sel | output | 3 | Positive input channel |
| neg_sel | output | 3 | Negative input channel, 7 = ground |
| result | output | 12 | Conversion result |
| done | output | 1 | One-cycle result-update strobe |

## Verification
The assertions check on every cycle that `done` lasts one cycle and comes after exactly twelve conversion cycles. They also check that acquisition never ends before its minimum, that there is no tracking while powered down or converting, that power and track after `done` follow the auto-shutdown setting, and that the mux selects are legal in both modes. Only the bench scenarios can show the full trigger latencies. These include the single-edge path from power-off, the falling edge when power is on, and the dual-edge case where a short pulse leaves a pending sample. The bench scenarios also show that edges on unselected sources or during a conversion are ignored, and that the result bits are the comparator samples taken in order.

// File: rtl/adc_ts_pkg.sv
package adc_ts_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PWRUP = 3'd1,
    ST_IDLE  = 3'd2,
    ST_ACQ   = 3'd3,
    ST_CONV  = 3'd4
  } seq_st_t;

  localparam logic [2:0] GND_SEL = 3'd7;

  // Returns {pos, neg} for a configuration code.
  function automatic logic [5:0] mux_decode(input logic diff, input logic [2:0] code);
    logic [2:0] p;
    logic [2:0] n;
    if (diff) begin
      p = (code == 3'd2) ? 3'd2 : 3'd0;
      n = p + 3'd1;
    end else begin
      p = (code <= 3'd4) ? code : 3'd0;
      n = GND_SEL;
    end
    return {p, n};
  endfunction

endpackage

// File: rtl/adc_ts_sync.sv
module adc_ts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/adc_ts_mux.sv
module adc_ts_mux
  import adc_ts_pkg::*;
(
  input  logic       diff_mode,
  input  logic [2:0] mux_code,
  output logic [2:0] pos_sel,
  output logic [2:0] neg_sel
);
  logic [5:0] dec;
  assign dec     = mux_decode(diff_mode, mux_code);
  assign pos_sel = dec[5:3];
  assign neg_sel = dec[2:0];
endmodule

// File: rtl/adc_ts_fsm.sv
module adc_ts_fsm
  import adc_ts_pkg::*;
#(
  parameter int PWR_CYC = 4,
  parameter int ACQ_CYC = 3,
  parameter int RES_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             dual_edge,
  input  logic             auto_off,
  input  logic             cmp_in,
  output logic             pwr_en,
  output logic             track,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             conv_active,
  output logic             acq_active
);
  localparam int MAXC = (PWR_CYC > ACQ_CYC) ? ((PWR_CYC > RES_W) ? PWR_CYC : RES_W)
                                            : ((ACQ_CYC > RES_W) ? ACQ_CYC : RES_W);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PWR_LAST = CW'(PWR_CYC - 1);
  localparam logic [CW-1:0] ACQ_LAST = CW'(ACQ_CYC - 1);
  localparam logic [CW-1:0] RES_LAST = CW'(RES_W - 1);

  seq_st_t          st;
  logic [CW-1:0]    cnt;
  logic             pend;
  logic [RES_W-1:0] sar;
  logic             idle_go;
  logic             acq_go;

  assign idle_go = dual_edge ? rise : fall;
  assign acq_go  = dual_edge ? (pend | fall) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_OFF;
      cnt    <= '0;
      pend   <= 1'b0;
      sar    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_OFF: if (rise) begin
          st   <= ST_PWRUP;
          cnt  <= '0;
          pend <= 1'b0;
        end
        ST_PWRUP: begin
          if (dual_edge && fall) pend <= 1'b1;
          if (cnt == PWR_LAST) begin
            st  <= ST_ACQ;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_IDLE: if (idle_go) begin
          st   <= ST_ACQ;
          cnt  <= '0;
          pend <= 1'b0;
        end
        ST_ACQ: begin
          if (dual_edge && fall) pend <= 1'b1;
          if (cnt != ACQ_LAST) cnt <= cnt + 1'b1;
          else if (acq_go) begin
            st   <= ST_CONV;
            cnt  <= '0;
            pend <= 1'b0;
            sar  <= '0;
          end
        end
        ST_CONV: begin
          sar <= {sar[RES_W-2:0], cmp_in};
          if (cnt == RES_LAST) begin
            result <= {sar[RES_W-2:0], cmp_in};
            done   <= 1'b1;
            st     <= auto_off ? ST_OFF : ST_IDLE;
            cnt    <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign pwr_en      = (st != ST_OFF);
  assign track       = (st == ST_IDLE) || (st == ST_ACQ);
  assign conv_active = (st == ST_CONV);
  assign acq_active  = (st == ST_ACQ);
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
  parameter int N_TMR   = 4,
  parameter int PWR_CYC = 4,
  parameter int ACQ_CYC = 3,
  parameter int RES_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_sel,
  input  logic             sw_start,
  input  logic             ext_start,
  input  logic [N_TMR-1:0] tmr_start,
  input  logic             dual_edge,
  input  logic             auto_off,
  input  logic             diff_mode,
  input  logic [2:0]       mux_code,
  input  logic             cmp_in,
  output logic             pwr_en,
  output logic             track,
  output logic [2:0]       pos_sel,
  output logic [2:0]       neg_sel,
  output logic [RES_W-1:0] result,
  output logic             done
);
  logic src_raw;
  logic src_rise;
  logic src_fall;
  logic conv_active;
  logic acq_active;

  always_comb begin
    src_raw = 1'b0;
    if (src_sel == 3'd0) src_raw = sw_start;
    if (src_sel == 3'd1) src_raw = ext_start;
    for (int i = 0; i < N_TMR; i++)
      if (32'(src_sel) == i + 2) src_raw = tmr_start[i];
  end

  adc_ts_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(src_raw), .rise(src_rise), .fall(src_fall)
  );

  adc_ts_fsm #(.PWR_CYC(PWR_CYC), .ACQ_CYC(ACQ_CYC), .RES_W(RES_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(src_rise), .fall(src_fall),
    .dual_edge(dual_edge), .auto_off(auto_off), .cmp_in(cmp_in),
    .pwr_en(pwr_en), .track(track), .result(result), .done(done),
    .conv_active(conv_active), .acq_active(acq_active)
  );

  adc_ts_mux u_mux (
    .diff_mode(diff_mode), .mux_code(mux_code), .pos_sel(pos_sel), .neg_sel(neg_sel)
  );
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk #(
  parameter int ACQ_CYC = 3,
  parameter int RES_W   = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_en,
  input logic       track,
  input logic       done,
  input logic       auto_off,
  input logic       diff_mode,
  input logic [2:0] pos_sel,
  input logic [2:0] neg_sel,
  input logic       conv_active,
  input logic       acq_active
);
  logic [7:0] conv_len;
  logic [7:0] acq_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_len <= '0;
      acq_len  <= '0;
    end else begin
      conv_len <= conv_active ? ((conv_len == 8'hFF) ? conv_len : conv_len + 8'd1) : 8'd0;
      acq_len  <= acq_active  ? ((acq_len  == 8'hFF) ? acq_len  : acq_len  + 8'd1) : 8'd0;
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_conv_len:   assert property (@(posedge clk) disable iff (!rst_n) done |-> conv_len == 8'(RES_W));
  a_r4_min_acq:    assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(conv_active) |-> acq_len >= 8'(ACQ_CYC));
  a_r5_retrack:    assert property (@(posedge clk) disable iff (!rst_n)
                     (done && !auto_off) |-> (pwr_en && track));
  a_r6_shutdown:   assert property (@(posedge clk) disable iff (!rst_n) (done && auto_off) |-> !pwr_en);
  a_r6_off_hold:   assert property (@(posedge clk) disable iff (!rst_n) !pwr_en |-> !track);
  a_r7_hold_conv:  assert property (@(posedge clk) disable iff (!rst_n) conv_active |-> !track);
  a_r9_single_dec: assert property (@(posedge clk) disable iff (!rst_n)
                     !diff_mode |-> (neg_sel == 3'd7 && pos_sel <= 3'd4));
  a_r10_diff_dec:  assert property (@(posedge clk) disable iff (!rst_n)
                     diff_mode |-> ((pos_sel == 3'd0 && neg_sel == 3'd1) ||
                                    (pos_sel == 3'd2 && neg_sel == 3'd3)));
endmodule

bind adc_trig_seq adc_trig_seq_chk #(.ACQ_CYC(ACQ_CYC), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .track(track), .done(done),
  .auto_off(auto_off), .diff_mode(diff_mode), .pos_sel(pos_sel), .neg_sel(neg_sel),
  .conv_active(conv_active), .acq_active(acq_active)
);

// File: tb/sim_adc_trig_seq.sv
`timescale 1ns/1ps
module sim_adc_trig_seq;
  localparam int PW = 4;
  localparam int AQ = 3;
  localparam int RW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic sw_start = 1'b0, ext_start = 1'b0;
  logic [3:0] tmr_start = 4'd0;
  logic dual_edge = 1'b0, auto_off = 1'b0, diff_mode = 1'b0;
  logic [2:0] mux_code = 3'd0;
  logic cmp_in = 1'b0;
  logic pwr_en, track, done;
  logic [2:0] pos_sel, neg_sel;
  logic [RW-1:0] result;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit is_on = 1'b0;
  bit finished = 1'b0;
  logic hist [0:255];

  adc_trig_seq u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_start(sw_start), .ext_start(ext_start),
    .tmr_start(tmr_start), .dual_edge(dual_edge), .auto_off(auto_off), .diff_mode(diff_mode),
    .mux_code(mux_code), .cmp_in(cmp_in), .pwr_en(pwr_en), .track(track),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .result(result), .done(done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    hist[cyc % 256] = cmp_in;
  end

  always @(negedge clk) cmp_in <= 1'($urandom);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] ref_mux(input logic diff, input logic [2:0] c);
    if (diff) return (c == 3'd2) ? {3'd2, 3'd3} : {3'd0, 3'd1};
    if (c > 3'd4) return {3'd0, 3'd7};
    return {c, 3'd7};
  endfunction

  task automatic drive_src(input logic [2:0] sel, input logic v);
    case (sel)
      3'd0: sw_start = v;
      3'd1: ext_start = v;
      3'd2, 3'd3, 3'd4, 3'd5: tmr_start[sel - 3'd2] = v;
      default: ;
    endcase
  endtask

  task automatic check_mux(input string req);
    #1;
    check(req, {26'd0, pos_sel, neg_sel}, {26'd0, ref_mux(diff_mode, mux_code)});
  endtask

  // Watches for done over n cycles; returns how many were seen.
  task automatic count_done(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
  endtask

  // One full trigger: pulse width w, optional injected pulse during conversion.
  task automatic run_conv(input string req, input bit dual, input int w, input bit inj);
    int t0, t1, expd, k, entry, got, extra;
    logic [RW-1:0] er;
    @(negedge clk);
    dual_edge = dual;
    @(negedge clk);
    t0 = cyc;
    drive_src(src_sel, 1'b1);
    repeat (w) @(negedge clk);
    t1 = cyc;
    drive_src(src_sel, 1'b0);
    if (!dual) begin
      if (!is_on) expd = t0 + 3 + PW + AQ + RW;
      else        expd = t1 + 3 + AQ + RW;
    end else begin
      k = t0 + 3 + (is_on ? 0 : PW);
      entry = (t1 + 3 > k + AQ) ? t1 + 3 : k + AQ;
      expd = entry + RW;
    end
    got = -1;
    while (got < 0 && cyc < expd + 6) begin
      if (inj && cyc == expd - 10) begin
        drive_src(src_sel, 1'b1);
        @(negedge clk);
        if (done) got = cyc;
        drive_src(src_sel, 1'b0);
      end
      @(negedge clk);
      if (done && got < 0) got = cyc;
    end
    check({req, " done edge"}, got, expd);
    if (got > 0) begin
      for (int i = 0; i < RW; i++) er[RW-1-i] = hist[(got - (RW-1) + i) % 256];
      check("R8 result bits", result, er);
      if (auto_off) check("R6 power off after done", pwr_en, 1'b0);
      else check("R5 power+track after done", {pwr_en, track}, 2'b11);
    end
    is_on = !auto_off;
    count_done(20, extra);
    check(inj ? "R7 no extra done" : "R8 single done", extra, 0);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 reset state", {pwr_en, track, done, 1'b0}, 4'b0000);
    check("R11 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 8; c++) begin
        diff_mode = d[0];
        mux_code = c[2:0];
        check_mux(d ? "R10 diff decode" : "R9 single decode");
      end

    // R1: unselected inputs have no effect
    src_sel = 3'd2;
    @(negedge clk);
    tmr_start[1] = 1'b1; sw_start = 1'b1; ext_start = 1'b1;
    repeat (4) @(negedge clk);
    tmr_start[1] = 1'b0; sw_start = 1'b0; ext_start = 1'b0;
    count_done(40, seen);
    check("R1 unselected ignored", {seen, pwr_en}, 0);
    src_sel = 3'd6;
    @(negedge clk);
    tmr_start = 4'hF; sw_start = 1'b1; ext_start = 1'b1;
    repeat (4) @(negedge clk);
    tmr_start = 4'h0; sw_start = 1'b0; ext_start = 1'b0;
    count_done(40, seen);
    check("R1 constant-low select", {seen, pwr_en}, 0);

    // Directed corner cases
    src_sel = 3'd3; auto_off = 1'b0;
    run_conv("R2 single from off", 1'b0, 3, 1'b0);
    run_conv("R3 single when on", 1'b0, 5, 1'b0);
    run_conv("R7 single with injected edges", 1'b0, 4, 1'b1);
    src_sel = 3'd1;
    run_conv("R4 dual short pulse pending", 1'b1, 2, 1'b0);
    run_conv("R4 dual long pulse", 1'b1, 12, 1'b1);
    auto_off = 1'b1;
    run_conv("R6 auto-off conversion", 1'b0, 6, 1'b0);
    run_conv("R6 power-up repeated", 1'b1, 9, 1'b0);
    auto_off = 1'b0;

    for (int it = 0; it < 40; it++) begin
      bit dl;
      int w;
      src_sel = 3'($urandom_range(0, 5));
      auto_off = 1'($urandom);
      diff_mode = 1'($urandom);
      mux_code = 3'($urandom);
      check_mux(diff_mode ? "R10 random decode" : "R9 random decode");
      dl = 1'($urandom);
      w = dl ? $urandom_range(2, 20) : $urandom_range(2, 6);
      run_conv(dl ? "R4 random dual" : (is_on ? "R3 random single" : "R2 random single"),
               dl, w, 1'($urandom));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0 cycles left", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule